// File: doc/BRIEF.md
# Register Save/Restore Stack Sequencer

This block performs the stack traffic of a small 32-bit processor. Given a one-cycle start with an operation code, a register selector and an immediate, it walks through a short sequence of word-wide memory accesses. Each access is a request held until an acknowledge arrives. Alongside the memory traffic it reads and writes the architectural registers through a register-file port. The stack pointer is held inside the block. It moves by one word address per slot: it is incremented before each store and decremented after each load.

Seven operations are supported. The single ones are push of a register, push of an immediate and pop into a register. The bulk ones save or restore all fifteen architectural registers: push-all walks them upward and pop-all walks them downward. Call saves the instruction pointer and then jumps to the jump-address register. Return pops the top of stack back into the instruction pointer. While an operation runs, `busy` is high. A one-cycle `done` marks its last cycle.

Top module: `stkseq`

## Requirements
- R1: After reset, busy, done, mem_req and rf_we are low and sp equals the SP_INIT parameter (default 16).
- R2: Operation code 0 (push register) first raises sp by one, then stores the register named by reg_sel at the new sp. When reg_sel is 13, the stored value is sp as it stood before the increment.
- R3: Operation code 1 (push immediate) first raises sp by one, then stores imm at the new sp.
- R4: Operation code 2 (pop register) loads the word at sp into register reg_sel through the register-file write port, then lowers sp by one.
- R5: Operation code 3 (push-all) stores register indices 0 to 14 in ascending order, one per slot. The slots lie at consecutive addresses starting at the entry sp plus one, so sp finishes 15 above its entry value. Indices 0-7 are the general registers, 8 HI, 9 LO, 10 flags, 11 control, 12 instruction pointer, 13 stack pointer and 14 jump address. The index-13 slot holds sp as it stood before that slot's increment.
- R6: Operation code 4 (pop-all) reads indices 14 down to 0 from descending addresses, starting at the entry sp. sp finishes 15 below its entry value. The index-13 word is read but discarded: register index 13 is never written.
- R7: Operation code 5 (call) pushes register 12 (instruction pointer) as in R2 and then writes register 12 with the value of register 14 (jump address).
- R8: Operation code 6 (return) pops the top of stack into register 12 and lowers sp by one.
- R9: A memory request, together with its address, write enable and write data, stays unchanged until mem_ack is seen high.
- R10: busy rises in the cycle after start is sampled and stays high through the single-cycle done pulse, falling in the cycle after it. A start that arrives while busy is ignored.
- R11: Operation code 2 with reg_sel 13 loads sp with the word read and does not decrement it.
- R12: Operation code 7 completes with a done pulse and makes no memory request and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| op | input | 3 | Operation code |
| reg_sel | input | 4 | Register index for single push/pop |
| imm | input | DW | Immediate for push immediate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | DW | Register-file read data (same-cycle) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | DW | Register-file write data |
| sp | output | AW | Current stack pointer |

## Verification
The assertions rest on three assumptions about the environment. The memory side acknowledges only while a request is up, and for at most one cycle per access. The register file returns read data in the same cycle as the index. The start input is not asserted while busy is high, or its ignored value has no meaning. The bench's memory model raises mem_ack for exactly one cycle after a programmable wait, and then drops it before looking at the next request. The register model reads combinationally. The single deliberate start during busy checks the ignore rule from the ports, and it never coincides with an acknowledge edge.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   typedef enum logic [2:0] {
      OP_PUSH_REG = 3'd0,
      OP_PUSH_IMM = 3'd1,
      OP_POP_REG  = 3'd2,
      OP_PUSH_ALL = 3'd3,
      OP_POP_ALL  = 3'd4,
      OP_CALL     = 3'd5,
      OP_RET      = 3'd6,
      OP_NONE     = 3'd7
   } stk_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_INC,
      S_WR,
      S_RD,
      S_DEC,
      S_JUMP,
      S_FIN
   } stk_state_e;

   localparam int unsigned RIDX_W    = 4;
   localparam int unsigned ARCH_REGS = 15;
   localparam logic [RIDX_W-1:0] RIDX_IP   = 4'd12;
   localparam logic [RIDX_W-1:0] RIDX_SP   = 4'd13;
   localparam logic [RIDX_W-1:0] RIDX_JMP  = 4'd14;
   localparam logic [RIDX_W-1:0] RIDX_LAST = RIDX_W'(ARCH_REGS - 1);

endpackage

// File: rtl/stkseq_ptr.sv
module stkseq_ptr #(
   parameter int unsigned   AW      = 32,
   parameter logic [AW-1:0] SP_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] sp
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("stkseq_ptr: AW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= SP_INIT;
      else if (load) sp <= load_val;
      else if (inc)  sp <= sp + AW'(1);
      else if (dec)  sp <= sp - AW'(1);
   end

   // R2 R4 R11: one pointer action per cycle
   always_comb begin
      ptr_one_action_chk: assert (!rst_n || $onehot0({inc, dec, load}));
   end

endmodule

// File: rtl/stkseq_walk.sv
module stkseq_walk #(
   parameter int unsigned IW   = 4,
   parameter int unsigned LAST = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [IW-1:0] load_val,
   input  logic          step,
   input  logic          down,
   output logic [IW-1:0] idx,
   output logic          at_end
);

   localparam logic [IW-1:0] LAST_IDX = IW'(LAST);

   generate
      if (LAST >= (1 << IW)) begin : g_bad_last
         $error("stkseq_walk: LAST does not fit in IW bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= load_val;
      else if (step) idx <= down ? idx - IW'(1) : idx + IW'(1);
   end

   assign at_end = down ? (idx == '0) : (idx == LAST_IDX);

endmodule

// File: rtl/stkseq.sv
module stkseq
   import stkseq_pkg::*;
#(
   parameter int unsigned   DW      = 32,
   parameter int unsigned   AW      = 32,
   parameter logic [AW-1:0] SP_INIT = AW'(16)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [RIDX_W-1:0] reg_sel,
   input  logic [DW-1:0]     imm,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ack,
   output logic [RIDX_W-1:0] rf_raddr,
   input  logic [DW-1:0]     rf_rdata,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [DW-1:0]     rf_wdata,
   output logic [AW-1:0]     sp
);

   generate
      if (AW > DW) begin : g_bad_width
         $error("stkseq: a stack pointer must fit in a data word");
      end
   endgenerate

   stk_state_e       state, nxt;
   stk_op_e          op_q;
   logic [DW-1:0]    imm_q;
   logic [DW-1:0]    wval_q;
   logic [DW-1:0]    slot_val;
   logic [RIDX_W-1:0] idx, first_idx;
   logic             at_end, multi;
   logic             w_load, w_step;
   logic             sp_inc, sp_dec, sp_load;

   stkseq_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_ptr (
      .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
      .load(sp_load), .load_val(mem_rdata[AW-1:0]), .sp(sp)
   );

   stkseq_walk #(.IW(RIDX_W), .LAST(ARCH_REGS - 1)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(first_idx),
      .step(w_step), .down(op_q == OP_POP_ALL), .idx(idx), .at_end(at_end)
   );

   assign multi = (op_q == OP_PUSH_ALL) || (op_q == OP_POP_ALL);
   assign busy  = (state != S_IDLE);
   assign done  = (state == S_FIN);

   // First register of the walk, chosen from the incoming code
   always_comb begin
      unique case (stk_op_e'(op))
         OP_PUSH_REG, OP_POP_REG: first_idx = reg_sel;
         OP_POP_ALL:              first_idx = RIDX_LAST;
         OP_CALL, OP_RET:         first_idx = RIDX_IP;
         default:                 first_idx = '0;
      endcase
   end

   // Value for a store slot: immediate, own pointer, or register file
   always_comb begin
      if (op_q == OP_PUSH_IMM)  slot_val = imm_q;
      else if (idx == RIDX_SP)  slot_val = DW'(sp);
      else                      slot_val = rf_rdata;
   end

   always_comb begin
      nxt       = state;
      w_load    = 1'b0;
      w_step    = 1'b0;
      sp_inc    = 1'b0;
      sp_dec    = 1'b0;
      sp_load   = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = sp;
      mem_wdata = wval_q;
      rf_raddr  = idx;
      rf_we     = 1'b0;
      rf_waddr  = idx;
      rf_wdata  = mem_rdata;
      unique case (state)
         S_IDLE: begin
            if (start) begin
               w_load = 1'b1;
               unique case (stk_op_e'(op))
                  OP_PUSH_REG, OP_PUSH_IMM, OP_PUSH_ALL, OP_CALL: nxt = S_INC;
                  OP_POP_REG, OP_POP_ALL, OP_RET:                 nxt = S_RD;
                  default:                                        nxt = S_FIN;
               endcase
            end
         end
         S_INC: begin
            sp_inc = 1'b1;
            nxt    = S_WR;
         end
         S_WR: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ack) begin
               if (multi && !at_end) begin
                  w_step = 1'b1;
                  nxt    = S_INC;
               end else if (op_q == OP_CALL) begin
                  nxt = S_JUMP;
               end else begin
                  nxt = S_FIN;
               end
            end
         end
         S_RD: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               if (idx != RIDX_SP) begin
                  rf_we = 1'b1;
                  nxt   = S_DEC;
               end else if (multi) begin
                  nxt = S_DEC;
               end else begin
                  sp_load = 1'b1;
                  nxt     = S_FIN;
               end
            end
         end
         S_DEC: begin
            sp_dec = 1'b1;
            if (multi && !at_end) begin
               w_step = 1'b1;
               nxt    = S_RD;
            end else begin
               nxt = S_FIN;
            end
         end
         S_JUMP: begin
            rf_raddr = RIDX_JMP;
            rf_we    = 1'b1;
            rf_waddr = RIDX_IP;
            rf_wdata = rf_rdata;
            nxt      = S_FIN;
         end
         S_FIN:   nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= OP_NONE;
         imm_q  <= '0;
         wval_q <= '0;
      end else begin
         state <= nxt;
         if (state == S_IDLE && start) begin
            op_q  <= stk_op_e'(op);
            imm_q <= imm;
         end
         if (state == S_INC) wval_q <= slot_val;
      end
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R10
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   // R2
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_INC) |=> (sp == $past(sp) + AW'(1)));

   // R4
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DEC) |=> (sp == $past(sp) - AW'(1)));

   // R6
   no_sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_waddr != RIDX_SP));

   // R12
   none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_NONE) |-> (!mem_req && !rf_we));

endmodule

// File: tb/stkseq_tb.sv
module stkseq_tb;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 32;
   localparam logic [31:0] SP0 = 32'd16;
   localparam int NV = 8;

   // op(3) reg_sel(4) imm(32) latency(4) expected sp after(8)
   localparam logic [50:0] VEC [NV] = '{
      {3'd0, 4'd3,  32'h0,         4'd0, 8'd17},
      {3'd1, 4'd0,  32'h5A5A_0001, 4'd1, 8'd18},
      {3'd2, 4'd5,  32'h0,         4'd2, 8'd17},
      {3'd0, 4'd13, 32'h0,         4'd0, 8'd18},
      {3'd5, 4'd0,  32'h0,         4'd1, 8'd19},
      {3'd6, 4'd0,  32'h0,         4'd3, 8'd18},
      {3'd2, 4'd9,  32'h0,         4'd0, 8'd17},
      {3'd0, 4'd9,  32'h0,         4'd3, 8'd18}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] op = 3'd7;
   logic [3:0] reg_sel = 4'd0;
   logic [DW-1:0] imm = '0;
   logic busy, done, mem_req, mem_we, rf_we;
   logic [AW-1:0] mem_addr, sp;
   logic [DW-1:0] mem_wdata, rf_wdata, rf_rdata;
   logic [DW-1:0] mem_rdata = '0;
   logic mem_ack = 1'b0;
   logic [3:0] rf_raddr, rf_waddr;

   always #2 clk = ~clk;

   stkseq #(.DW(DW), .AW(AW), .SP_INIT(SP0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_sel(reg_sel),
      .imm(imm), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sp(sp)
   );

   int checks = 0;
   int fails = 0;
   int lat = 0;
   int wait_cnt = 0;
   int hold_err = 0;
   int req_cycles = 0;
   int done_cnt = 0;

   logic [31:0] mem [64];
   logic [31:0] rf [16];
   logic [31:0] wlog_a [256];
   logic [31:0] rlog_a [256];
   logic [3:0]  rflog [256];
   int wn = 0, rn = 0, rfn = 0;
   logic pend = 1'b0;
   logic [31:0] pend_addr = '0;

   logic [31:0] m_mem [64];
   logic [31:0] m_rf [16];
   logic [31:0] m_sp;

   function automatic logic [31:0] init_reg(int i);
      return 32'hA500_0000 | (32'(i) << 8) | 32'(i);
   endfunction

   assign rf_rdata = rf[rf_raddr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) rf[i] <= init_reg(i);
      end else if (rf_we) begin
         rf[rf_waddr] <= rf_wdata;
         rflog[rfn[7:0]] = rf_waddr;
         rfn++;
      end
   end

   // Memory responder: one-cycle acknowledge after lat waiting cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] = '0;
         mem_ack = 1'b0;
         wait_cnt = 0;
         pend = 1'b0;
      end else begin
         if (mem_req) req_cycles++;
         if (done) done_cnt++;
         if (pend && mem_req && mem_addr != pend_addr) hold_err++;
         pend = 1'b0;
         if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
         end else if (mem_req) begin
            if (wait_cnt >= lat) begin
               mem_ack = 1'b1;
               if (mem_we) begin
                  mem[mem_addr[5:0]] = mem_wdata;
                  wlog_a[wn[7:0]] = mem_addr;
                  wn++;
               end else begin
                  mem_rdata = mem[mem_addr[5:0]];
                  rlog_a[rn[7:0]] = mem_addr;
                  rn++;
               end
            end else begin
               wait_cnt++;
               pend = 1'b1;
               pend_addr = mem_addr;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(logic [2:0] c);
      case (c)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic model(input logic [2:0] c, input logic [3:0] r, input logic [31:0] iv);
      case (c)
         3'd0: begin
            logic [31:0] v;
            v = (r == 4'd13) ? m_sp : m_rf[r];
            m_sp++; m_mem[m_sp[5:0]] = v;
         end
         3'd1: begin m_sp++; m_mem[m_sp[5:0]] = iv; end
         3'd2: begin
            if (r == 4'd13) m_sp = m_mem[m_sp[5:0]];
            else begin m_rf[r] = m_mem[m_sp[5:0]]; m_sp--; end
         end
         3'd3: for (int k = 0; k < 15; k++) begin
            logic [31:0] v;
            v = (k == 13) ? m_sp : m_rf[k];
            m_sp++; m_mem[m_sp[5:0]] = v;
         end
         3'd4: for (int k = 14; k >= 0; k--) begin
            if (k != 13) m_rf[k] = m_mem[m_sp[5:0]];
            m_sp--;
         end
         3'd5: begin
            m_sp++; m_mem[m_sp[5:0]] = m_rf[12]; m_rf[12] = m_rf[14];
         end
         3'd6: begin m_rf[12] = m_mem[m_sp[5:0]]; m_sp--; end
         default: ;
      endcase
   endtask

   // Drive one operation; optional second start while busy (R10)
   task automatic run_op(input logic [2:0] c, input logic [3:0] r, input logic [31:0] iv,
                         input int l, input bit poke);
      int n;
      string rq;
      rq = req_of(c);
      lat = l;
      @(negedge clk);
      start = 1'b1; op = c; reg_sel = r; imm = iv;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
      n = 0;
      while (done !== 1'b1 && n < 400) begin
         if (poke && n == 3) begin
            start = 1'b1; op = 3'd1; imm = 32'hDEAD_BEEF;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(done === 1'b1, rq, "done seen", 32'(done), 32'd1);
      chk(busy === 1'b1, "R10", "busy during done", 32'(busy), 32'd1);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R10", "idle after done",
          {30'd0, busy, done}, 32'd0);
      model(c, r, iv);
   endtask

   task automatic compare_state(input string rq);
      int bad;
      chk(sp === m_sp, rq, "sp", sp, m_sp);
      bad = 0;
      for (int i = 0; i < 15; i++) if (rf[i] !== m_rf[i]) bad++;
      chk(bad == 0, rq, "register mismatches", 32'(bad), 32'd0);
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== m_mem[i]) bad++;
      chk(bad == 0, rq, "memory mismatches", 32'(bad), 32'd0);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_rf[i] = init_reg(i);
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      m_sp = SP0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", {30'd0, busy, done}, 32'd0);
      chk(mem_req === 1'b0 && rf_we === 1'b0, "R1", "req/we", {30'd0, mem_req, rf_we}, 32'd0);
      chk(sp === SP0, "R1", "sp", sp, SP0);

      // Table walk: single ops, call, return
      for (int v = 0; v < NV; v++) begin
         logic [50:0] e;
         e = VEC[v];
         run_op(e[50:48], e[47:44], e[43:12], int'(e[11:8]), 1'b0);
         compare_state(req_of(e[50:48]));
         chk(sp === 32'(e[7:0]), req_of(e[50:48]), "table sp", sp, 32'(e[7:0]));
      end

      // R5 push-all, with a start pulse during busy (R10)
      begin
         int w0, d0;
         logic [31:0] base;
         bit ordok;
         w0 = wn; d0 = done_cnt; base = sp;
         run_op(3'd3, 4'd0, 32'h0, 1, 1'b1);
         compare_state("R5");
         chk(wn - w0 == 15, "R5", "store count", 32'(wn - w0), 32'd15);
         ordok = 1'b1;
         for (int k = 0; k < 15; k++)
            if (wlog_a[(w0 + k) % 256] !== base + 32'(k) + 32'd1) ordok = 1'b0;
         chk(ordok, "R5", "ascending slot addresses", 32'(ordok), 32'd1);
         chk(mem[(base + 32'd14) & 32'h3F] === base + 32'd13, "R5", "saved sp slot",
             mem[(base + 32'd14) & 32'h3F], base + 32'd13);
         @(negedge clk);
         chk(done_cnt - d0 == 1 && busy === 1'b0, "R10", "start while busy ignored",
             32'(done_cnt - d0), 32'd1);
      end

      // R6 pop-all order and skipped index 13
      begin
         int f0, r0;
         bit ordok;
         int exp_i;
         f0 = rfn; r0 = rn;
         for (int i = 0; i < 15; i++) m_rf[i] = init_reg(i);
         run_op(3'd4, 4'd0, 32'h0, 0, 1'b0);
         compare_state("R6");
         chk(rn - r0 == 15, "R6", "load count", 32'(rn - r0), 32'd15);
         chk(rfn - f0 == 14, "R6", "register writes", 32'(rfn - f0), 32'd14);
         ordok = 1'b1;
         exp_i = 14;
         for (int k = 0; k < 14; k++) begin
            if (exp_i == 13) exp_i = 12;
            if (rflog[(f0 + k) % 256] !== 4'(exp_i)) ordok = 1'b0;
            exp_i--;
         end
         chk(ordok, "R6", "descending write order", 32'(ordok), 32'd1);
      end

      // R9 request held while waiting
      chk(hold_err == 0, "R9", "address changed before ack", 32'(hold_err), 32'd0);

      // R12 reserved code
      begin
         int q0;
         q0 = req_cycles;
         run_op(3'd7, 4'd2, 32'h0, 0, 1'b0);
         chk(req_cycles == q0, "R12", "memory requests", 32'(req_cycles - q0), 32'd0);
         compare_state("R12");
      end

      // R11 pop into the stack pointer
      run_op(3'd1, 4'd0, 32'd5, 2, 1'b0);
      compare_state("R3");
      run_op(3'd2, 4'd13, 32'h0, 1, 1'b0);
      chk(sp === 32'd5, "R11", "sp loaded", sp, 32'd5);
      compare_state("R11");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule